// File: doc/BRIEF.md
# Forth Dual-Stack Execution Unit

This unit keeps the two stacks of a small stack machine, a data stack for operands and a return stack, both with 16 entries of 16 bits. Each clock it can take one primitive, named by a 5-bit opcode. The primitives cover the stack shuffles, transfers between the two stacks, addition, subtraction and comparisons that leave a Forth flag. A separate literal port pushes a constant word onto the data stack. The surrounding sequencer drives opcodes and literals. It reads back the top two data entries, both depths and an error code.

Every primitive first checks that enough items are present and that there is room for the result. A shortage of items or a full stack is a fault. A fault records a numbered error and empties both stacks, which is the same cleanup that the abort primitive does. A small controller has two states. `ST_IDLE` means nothing was accepted on the previous edge. `ST_ACK` means something was. The transition `ST_IDLE -> ST_ACK` and the self-loop `ST_ACK -> ST_ACK` are taken on any edge that accepts an opcode or literal. `ST_ACK -> ST_IDLE` and the self-loop `ST_IDLE -> ST_IDLE` are taken on an edge with nothing to accept. Reset forces `ST_IDLE`.

Top module: `forth_stack_engine`

## Requirements
- R1: Synchronous active-high `rst` empties both stacks, clears the error code and drops `op_done`, so `tos`, `nos`, `ds_depth`, `rs_depth`, `err_code` and `op_done` all read 0 after the reset edge, whatever the strobes do.
- R2: With `lit_valid` high and `op_valid` low, `lit_data` is pushed onto the data stack: after the edge `tos` equals it and `ds_depth` has grown by one.
- R3: Shuffles act on the data stack, with top T, second S and third U. dup (5'b00101) pushes T. over (5'b00111) pushes S. swap (5'b01000) exchanges T and S. rot (5'b01110) turns U S T into S T U, so U becomes the top. drop (5'b01101) removes T.
- R4: Return transfers work as follows. to-return (5'b01001) pops T from the data stack and pushes it onto the return stack. from-return (5'b01011) pops the return top and pushes it onto the data stack. copy-return (5'b01100) pushes the return top onto the data stack and leaves the return stack as it was.
- R5: plus (5'b10111) replaces T and S with S+T. minus (5'b11000) replaces them with S-T. Both are taken modulo 2^16, and the data depth drops by one.
- R6: The flags are true = 16'hFFFF and false = 16'h0000. equal (5'b01111) replaces S and T with the flag S==T. greater-than (5'b10001) uses signed S>T and less-than (5'b10011) uses signed S<T, and both also consume two items. zero-equal (5'b10000) replaces T with the flag T==0 and leaves the depth as it is.
- R7: Some primitives find too few items. dup, drop, zero-equal and to-return need 1 data item. swap, over and the two-operand arithmetic and compare primitives need 2. rot needs 3. from-return and copy-return need 1 return item. A shortage sets `err_code` to 2 for the data stack or 4 for the return stack and empties both stacks. The data-stack check comes first.
- R8: A push onto a stack that already holds 16 items sets `err_code` to 1 for the data stack or 3 for the return stack and empties both stacks. This covers literal pushes, dup, over, from-return, copy-return and to-return. Underflow checks take precedence over overflow checks.
- R9: abort (5'b00001) empties both stacks and sets `err_code` to 0.
- R10: Any opcode not listed in R3 to R9 sets `err_code` to 5 and leaves both stacks, and therefore `tos`, `nos` and both depths, unchanged.
- R11: `err_code` keeps its value across successful primitives and idle cycles. Only abort, reset or a later fault changes it, and a later fault replaces it with its own code.
- R12: `op_done` is high for exactly the cycle after each edge that accepts an opcode or a literal, and low after an edge with neither strobe.
- R13: When `op_valid` and `lit_valid` are high together, only the opcode executes and the literal is discarded.
- R14: `tos` reads 0 when the data stack is empty, and `nos` reads 0 when fewer than two items are present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 5 | Primitive to execute |
| lit_valid | input | 1 | Literal push strobe |
| lit_data | input | 16 | Literal word |
| tos | output | 16 | Top data-stack entry |
| nos | output | 16 | Second data-stack entry |
| ds_depth | output | 5 | Data-stack item count |
| rs_depth | output | 5 | Return-stack item count |
| op_done | output | 1 | Acceptance pulse, one cycle after the edge |
| err_code | output | 16 | Latest error number |

## Verification
An opcode strobe and a literal push can arrive on the same edge, and the opcode must win. The bench raises both strobes together, with the opcode at several data depths. It judges the result by comparing the depth, the top two entries and the error code with the outcome of the opcode alone. A second collision inside one primitive is a push that needs room on a full stack after its operand check has passed. Directed sequences fill each stack to 16 and then issue dup, from-return, copy-return, to-return and a literal. The bench expects overflow to empty both stacks and leave the matching code.

// File: rtl/forth_pkg.sv
package forth_pkg;

    typedef enum logic [4:0] {
        OP_ABORT  = 5'b00001,
        OP_DUP    = 5'b00101,
        OP_OVER   = 5'b00111,
        OP_SWAP   = 5'b01000,
        OP_TO_R   = 5'b01001,
        OP_FROM_R = 5'b01011,
        OP_COPY_R = 5'b01100,
        OP_DROP   = 5'b01101,
        OP_ROT    = 5'b01110,
        OP_EQ     = 5'b01111,
        OP_ZEQ    = 5'b10000,
        OP_GT     = 5'b10001,
        OP_LT     = 5'b10011,
        OP_PLUS   = 5'b10111,
        OP_MINUS  = 5'b11000
    } op_e;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_DS_OVF = 3'd1,
        ERR_DS_UNF = 3'd2,
        ERR_RS_OVF = 3'd3,
        ERR_RS_UNF = 3'd4,
        ERR_BAD_OP = 3'd5
    } err_e;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } fsm_e;

    // Per-opcode requirements and stack motion
    typedef struct packed {
        logic       legal;
        logic       abort;
        logic [1:0] need_d;
        logic       need_r;
        logic       d_grow;
        logic       d_shrink;
        logic       r_grow;
        logic       r_shrink;
        logic       alu;
    } dec_t;

endpackage

// File: rtl/forth_decode.sv
module forth_decode
    import forth_pkg::*;
(
    input  op_e  op,
    output dec_t dec
);
    always_comb begin
        dec = '0;
        dec.legal = 1'b1;
        unique case (op)
            OP_ABORT:  dec.abort = 1'b1;
            OP_DUP:    begin dec.need_d = 2'd1; dec.d_grow = 1'b1; end
            OP_OVER:   begin dec.need_d = 2'd2; dec.d_grow = 1'b1; end
            OP_SWAP:   dec.need_d = 2'd2;
            OP_ROT:    dec.need_d = 2'd3;
            OP_DROP:   begin dec.need_d = 2'd1; dec.d_shrink = 1'b1; end
            OP_TO_R:   begin
                dec.need_d   = 2'd1;
                dec.d_shrink = 1'b1;
                dec.r_grow   = 1'b1;
            end
            OP_FROM_R: begin
                dec.need_r   = 1'b1;
                dec.d_grow   = 1'b1;
                dec.r_shrink = 1'b1;
            end
            OP_COPY_R: begin dec.need_r = 1'b1; dec.d_grow = 1'b1; end
            OP_EQ, OP_GT, OP_LT, OP_PLUS, OP_MINUS: begin
                dec.need_d   = 2'd2;
                dec.d_shrink = 1'b1;
                dec.alu      = 1'b1;
            end
            OP_ZEQ:    begin dec.need_d = 2'd1; dec.alu = 1'b1; end
            default:   dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/forth_alu.sv
module forth_alu
    import forth_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] top,
    input  logic [W-1:0] sec,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] FLAG_T = {W{1'b1}};
    localparam logic [W-1:0] FLAG_F = '0;

    always_comb begin
        unique case (op)
            OP_PLUS:  res = sec + top;
            OP_MINUS: res = sec - top;
            OP_EQ:    res = (sec == top) ? FLAG_T : FLAG_F;
            OP_ZEQ:   res = (top == '0) ? FLAG_T : FLAG_F;
            OP_GT:    res = ($signed(sec) > $signed(top)) ? FLAG_T : FLAG_F;
            OP_LT:    res = ($signed(sec) < $signed(top)) ? FLAG_T : FLAG_F;
            default:  res = FLAG_F;
        endcase
    end
endmodule

// File: rtl/forth_stack.sv
module forth_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int TAPS  = 3,
    parameter int PW    = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            upd,
    input  logic [PW-1:0]   nxt_ptr,
    input  logic [TAPS-1:0] we,
    input  logic [TAPS*W-1:0] wd,
    output logic [TAPS*W-1:0] rd,
    output logic [PW-1:0]   ptr
);
    logic [W-1:0] mem [DEPTH];

    // Pointer names the next free slot
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= '0;
        end else if (upd) begin
            ptr <= nxt_ptr;
        end
    end

    // Tap k writes the slot k below the new top
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            for (int k = TAPS - 1; k >= 0; k--) begin
                if (!rst && !clr && we[k] && nxt_ptr == PW'(i + k + 1)) begin
                    mem[i] <= wd[k*W +: W];
                end
            end
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign rd[k*W +: W] = (ptr > PW'(k)) ? mem[AW'(ptr - PW'(k + 1))] : '0;
    end

    a_r8_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        ptr <= PW'(DEPTH));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == '0));
endmodule

// File: rtl/forth_stack_engine.sv
module forth_stack_engine
    import forth_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PW    = $clog2(DEPTH + 1),
    localparam int OP_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              lit_valid,
    input  logic [DATA_W-1:0] lit_data,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic [PW-1:0]     ds_depth,
    output logic [PW-1:0]     rs_depth,
    output logic              op_done,
    output logic [DATA_W-1:0] err_code
);
    localparam int DS_TAPS = 3;
    localparam int RS_TAPS = 1;

    op_e  op_sel;
    dec_t dec;
    fsm_e st_q, st_d;
    logic [2:0] err_q, err_d;
    logic accept;

    logic ds_clr, ds_upd, rs_clr, rs_upd;
    logic [PW-1:0] ds_nxt, rs_nxt;
    logic [DS_TAPS-1:0] ds_we;
    logic [RS_TAPS-1:0] rs_we;
    logic [DS_TAPS*DATA_W-1:0] ds_wd, ds_rd;
    logic [RS_TAPS*DATA_W-1:0] rs_wd, rs_rd;
    logic [DATA_W-1:0] ds_t0, ds_t1, ds_t2, rs_t0, alu_res;
    logic uf_d, uf_r, of_d, of_r;

    assign op_sel = op_e'(op_code);
    assign accept = op_valid || lit_valid;

    forth_decode u_decode (.op(op_sel), .dec(dec));

    assign ds_t0 = ds_rd[0*DATA_W +: DATA_W];
    assign ds_t1 = ds_rd[1*DATA_W +: DATA_W];
    assign ds_t2 = ds_rd[2*DATA_W +: DATA_W];
    assign rs_t0 = rs_rd[DATA_W-1:0];

    forth_alu #(.W(DATA_W)) u_alu (
        .op(op_sel), .top(ds_t0), .sec(ds_t1), .res(alu_res)
    );

    forth_stack #(.W(DATA_W), .DEPTH(DEPTH), .TAPS(DS_TAPS)) u_dstack (
        .clk(clk), .rst(rst), .clr(ds_clr), .upd(ds_upd), .nxt_ptr(ds_nxt),
        .we(ds_we), .wd(ds_wd), .rd(ds_rd), .ptr(ds_depth)
    );

    forth_stack #(.W(DATA_W), .DEPTH(DEPTH), .TAPS(RS_TAPS)) u_rstack (
        .clk(clk), .rst(rst), .clr(rs_clr), .upd(rs_upd), .nxt_ptr(rs_nxt),
        .we(rs_we), .wd(rs_wd), .rd(rs_rd), .ptr(rs_depth)
    );

    // Operand and room checks, ahead of any change
    assign uf_d = ds_depth < PW'(dec.need_d);
    assign uf_r = dec.need_r && (rs_depth == '0);
    assign of_d = dec.d_grow && (ds_depth == PW'(DEPTH));
    assign of_r = dec.r_grow && (rs_depth == PW'(DEPTH));

    always_comb begin
        ds_clr = 1'b0;  rs_clr = 1'b0;
        ds_upd = 1'b0;  rs_upd = 1'b0;
        ds_nxt = ds_depth;
        rs_nxt = rs_depth;
        ds_we  = '0;    rs_we  = '0;
        ds_wd  = '0;    rs_wd  = '0;
        err_d  = err_q;
        if (op_valid) begin
            if (!dec.legal) begin
                err_d = ERR_BAD_OP;
            end else if (dec.abort) begin
                ds_clr = 1'b1; rs_clr = 1'b1; err_d = ERR_NONE;
            end else if (uf_d) begin
                ds_clr = 1'b1; rs_clr = 1'b1; err_d = ERR_DS_UNF;
            end else if (uf_r) begin
                ds_clr = 1'b1; rs_clr = 1'b1; err_d = ERR_RS_UNF;
            end else if (of_d) begin
                ds_clr = 1'b1; rs_clr = 1'b1; err_d = ERR_DS_OVF;
            end else if (of_r) begin
                ds_clr = 1'b1; rs_clr = 1'b1; err_d = ERR_RS_OVF;
            end else begin
                ds_upd = 1'b1;
                rs_upd = 1'b1;
                ds_nxt = ds_depth + PW'(dec.d_grow) - PW'(dec.d_shrink);
                rs_nxt = rs_depth + PW'(dec.r_grow) - PW'(dec.r_shrink);
                unique case (op_sel)
                    OP_DUP:  begin ds_we = 3'b001; ds_wd[DATA_W-1:0] = ds_t0; end
                    OP_OVER: begin ds_we = 3'b001; ds_wd[DATA_W-1:0] = ds_t1; end
                    OP_SWAP: begin
                        ds_we = 3'b011;
                        ds_wd[0*DATA_W +: DATA_W] = ds_t1;
                        ds_wd[1*DATA_W +: DATA_W] = ds_t0;
                    end
                    OP_ROT: begin
                        ds_we = 3'b111;
                        ds_wd[0*DATA_W +: DATA_W] = ds_t2;
                        ds_wd[1*DATA_W +: DATA_W] = ds_t0;
                        ds_wd[2*DATA_W +: DATA_W] = ds_t1;
                    end
                    OP_TO_R: begin rs_we = 1'b1; rs_wd = ds_t0; end
                    OP_FROM_R, OP_COPY_R: begin
                        ds_we = 3'b001; ds_wd[DATA_W-1:0] = rs_t0;
                    end
                    default: begin
                        if (dec.alu) begin
                            ds_we = 3'b001;
                            ds_wd[DATA_W-1:0] = alu_res;
                        end
                    end
                endcase
            end
        end else if (lit_valid) begin
            if (ds_depth == PW'(DEPTH)) begin
                ds_clr = 1'b1; rs_clr = 1'b1; err_d = ERR_DS_OVF;
            end else begin
                ds_upd = 1'b1;
                ds_nxt = ds_depth + PW'(1);
                ds_we  = 3'b001;
                ds_wd[DATA_W-1:0] = lit_data;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            err_q <= ERR_NONE;
        end else begin
            st_q  <= st_d;
            err_q <= err_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = accept ? ST_ACK : ST_IDLE;
            ST_ACK:  st_d = accept ? ST_ACK : ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        op_done  = (st_q == ST_ACK);
        tos      = ds_t0;
        nos      = ds_t1;
        err_code = DATA_W'(err_q);
    end

    a_r12_done_follows: assert property (@(posedge clk) disable iff (rst)
        accept |=> op_done);

    a_r12_done_quiet: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !op_done);

    a_r9_abort_clears: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_ABORT) |=>
            (ds_depth == '0 && rs_depth == '0 && err_code == '0));

    a_r10_invalid_keeps: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !dec.legal) |=>
            (err_code == DATA_W'(5) && $stable(ds_depth) && $stable(rs_depth)));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(err_code));

    a_r8_lit_overflow: assert property (@(posedge clk) disable iff (rst)
        (lit_valid && !op_valid && ds_depth == PW'(DEPTH)) |=>
            (err_code == DATA_W'(1) && ds_depth == '0 && rs_depth == '0));

    a_r13_op_priority: assert property (@(posedge clk) disable iff (rst)
        (op_valid && lit_valid && op_code == OP_DROP && ds_depth != '0) |=>
            (ds_depth == $past(ds_depth) - PW'(1)));
endmodule

// File: tb/forth_stack_engine_bench.sv
module forth_stack_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    localparam logic [4:0] C_ABORT = 5'b00001, C_DUP = 5'b00101, C_OVER = 5'b00111,
        C_SWAP = 5'b01000, C_TO_R = 5'b01001, C_FROM_R = 5'b01011, C_COPY_R = 5'b01100,
        C_DROP = 5'b01101, C_ROT = 5'b01110, C_EQ = 5'b01111, C_ZEQ = 5'b10000,
        C_GT = 5'b10001, C_LT = 5'b10011, C_PLUS = 5'b10111, C_MINUS = 5'b11000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic lit_valid = 1'b0;
    logic [15:0] lit_data = '0;
    logic [15:0] tos, nos, err_code;
    logic [4:0] ds_depth, rs_depth;
    logic op_done;

    forth_stack_engine u_forth_stack_engine (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .lit_valid(lit_valid), .lit_data(lit_data), .tos(tos), .nos(nos),
        .ds_depth(ds_depth), .rs_depth(rs_depth), .op_done(op_done),
        .err_code(err_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [15:0] m_ds [DEPTH];
    logic [15:0] m_rs [DEPTH];
    int m_dd = 0;
    int m_rd = 0;
    logic [15:0] m_err = '0;
    string m_tag = "R1";
    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] m_at(input int k);
        return (m_dd > k) ? m_ds[m_dd - 1 - k] : 16'h0000;
    endfunction

    function automatic logic [15:0] flag(input bit b);
        return b ? 16'hFFFF : 16'h0000;
    endfunction

    task automatic m_fault(input int code, input string tag);
        m_err = 16'(code); m_dd = 0; m_rd = 0; m_tag = tag;
    endtask

    task automatic m_exec(input logic [4:0] c);
        logic [15:0] t, s, u;
        t = m_at(0); s = m_at(1); u = m_at(2);
        case (c)
            C_ABORT: begin m_dd = 0; m_rd = 0; m_err = '0; m_tag = "R9"; end
            C_DUP, C_OVER: begin
                if (m_dd < ((c == C_DUP) ? 1 : 2)) m_fault(2, "R7");
                else if (m_dd == DEPTH) m_fault(1, "R8");
                else begin m_ds[m_dd] = (c == C_DUP) ? t : s; m_dd++; m_tag = "R3"; end
            end
            C_SWAP: begin
                if (m_dd < 2) m_fault(2, "R7");
                else begin m_ds[m_dd-1] = s; m_ds[m_dd-2] = t; m_tag = "R3"; end
            end
            C_ROT: begin
                if (m_dd < 3) m_fault(2, "R7");
                else begin
                    m_ds[m_dd-1] = u; m_ds[m_dd-2] = t; m_ds[m_dd-3] = s; m_tag = "R3";
                end
            end
            C_DROP: begin
                if (m_dd < 1) m_fault(2, "R7");
                else begin m_dd--; m_tag = "R3"; end
            end
            C_TO_R: begin
                if (m_dd < 1) m_fault(2, "R7");
                else if (m_rd == DEPTH) m_fault(3, "R8");
                else begin m_rs[m_rd] = t; m_rd++; m_dd--; m_tag = "R4"; end
            end
            C_FROM_R, C_COPY_R: begin
                if (m_rd < 1) m_fault(4, "R7");
                else if (m_dd == DEPTH) m_fault(1, "R8");
                else begin
                    m_ds[m_dd] = m_rs[m_rd-1]; m_dd++;
                    if (c == C_FROM_R) m_rd--;
                    m_tag = "R4";
                end
            end
            C_EQ, C_GT, C_LT, C_PLUS, C_MINUS: begin
                if (m_dd < 2) m_fault(2, "R7");
                else begin
                    case (c)
                        C_EQ:    m_ds[m_dd-2] = flag(s == t);
                        C_GT:    m_ds[m_dd-2] = flag($signed(s) > $signed(t));
                        C_LT:    m_ds[m_dd-2] = flag($signed(s) < $signed(t));
                        C_PLUS:  m_ds[m_dd-2] = s + t;
                        default: m_ds[m_dd-2] = s - t;
                    endcase
                    m_dd--;
                    m_tag = (c == C_PLUS || c == C_MINUS) ? "R5" : "R6";
                end
            end
            C_ZEQ: begin
                if (m_dd < 1) m_fault(2, "R7");
                else begin m_ds[m_dd-1] = flag(t == 16'h0000); m_tag = "R6"; end
            end
            default: begin m_err = 16'd5; m_tag = "R10"; end
        endcase
    endtask

    task automatic m_lit(input logic [15:0] v);
        if (m_dd == DEPTH) m_fault(1, "R8");
        else begin m_ds[m_dd] = v; m_dd++; m_tag = "R2"; end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "tos (R14)", tos, m_at(0));
        chk(tag, "nos (R14)", nos, m_at(1));
        chk(tag, "ds_depth", 16'(ds_depth), 16'(m_dd));
        chk(tag, "rs_depth", 16'(rs_depth), 16'(m_rd));
        chk(tag, "err_code (R11)", err_code, m_err);
    endtask

    // One accepted action; inputs driven and outputs sampled at falling edges
    task automatic apply(input bit ov, input logic [4:0] c, input bit lv, input logic [15:0] d);
        @(negedge clk);
        chk("R12", "op_done idle", 16'(op_done), 16'h0000);
        op_valid = ov; op_code = c; lit_valid = lv; lit_data = d;
        @(posedge clk);
        if (ov) m_exec(c);
        else if (lv) m_lit(d);
        if (ov && lv) m_tag = "R13";
        @(negedge clk);
        op_valid = 1'b0; lit_valid = 1'b0;
        compare_all(m_tag);
        chk("R12", "op_done pulse", 16'(op_done), 16'h0001);
    endtask

    task automatic do_op(input logic [4:0] c);
        apply(1'b1, c, 1'b0, 16'h0000);
    endtask

    task automatic do_lit(input logic [15:0] v);
        apply(1'b0, 5'b00000, 1'b1, v);
    endtask

    function automatic logic [15:0] pick_val(input int k, input int vv, input int c);
        case (vv)
            0:       return 16'((k + 1) * 16'h1234 + c);
            1:       return 16'h0042;
            default: return (k % 3 == 0) ? 16'h0000 : ((k % 3 == 1) ? 16'h8000 : 16'h7FFF);
        endcase
    endfunction

    function automatic logic [15:0] edge_val(input int i);
        case (i)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7FFF; 3: return 16'h8000;
            4: return 16'hFFFF; 5: return 16'h1234; 6: return 16'hFFFE; default: return 16'h8001;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL R12 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates active strobes
        rst = 1'b1; op_valid = 1'b1; op_code = C_DUP; lit_valid = 1'b1; lit_data = 16'hBEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; lit_valid = 1'b0;
        m_dd = 0; m_rd = 0; m_err = '0;
        compare_all("R1");
        chk("R1", "op_done", 16'(op_done), 16'h0000);
        rst = 1'b0;

        // Sweep every opcode over small stack configurations
        for (int c = 0; c < 32; c++) begin
            for (int rdep = 0; rdep < 2; rdep++) begin
                for (int ddep = 0; ddep < 4; ddep++) begin
                    for (int vv = 0; vv < 3; vv++) begin
                        do_op(C_ABORT);
                        if (rdep == 1) begin
                            do_lit(16'hA5A5 ^ 16'(c));
                            do_op(C_TO_R);
                        end
                        for (int k = 0; k < ddep; k++) do_lit(pick_val(k, vv, c));
                        do_op(5'(c));
                    end
                end
            end
        end

        // R5, R6: operand pairs at signed and unsigned edges
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int o = 0; o < 6; o++) begin
                    logic [4:0] oc;
                    oc = (o == 0) ? C_PLUS : (o == 1) ? C_MINUS : (o == 2) ? C_GT :
                         (o == 3) ? C_LT : (o == 4) ? C_EQ : C_ZEQ;
                    do_op(C_ABORT);
                    do_lit(edge_val(i));
                    do_lit(edge_val(j));
                    do_op(oc);
                end
            end
        end

        // R8: data overflow by literal, dup and from-return
        do_op(C_ABORT);
        for (int k = 0; k < DEPTH; k++) do_lit(16'(k * 7 + 1));
        do_lit(16'h9999);
        for (int k = 0; k < DEPTH; k++) do_lit(16'(k));
        do_op(C_DUP);
        do_op(C_ABORT);
        do_lit(16'h0BAD); do_op(C_TO_R);
        for (int k = 0; k < DEPTH; k++) do_lit(16'(k + 3));
        do_op(C_FROM_R);
        do_op(C_ABORT);
        do_lit(16'h0C0D); do_op(C_TO_R);
        for (int k = 0; k < DEPTH; k++) do_lit(16'(k + 5));
        do_op(C_COPY_R);

        // R8: return overflow
        do_op(C_ABORT);
        for (int k = 0; k < DEPTH; k++) begin do_lit(16'(k + 100)); do_op(C_TO_R); end
        do_lit(16'h4444);
        do_op(C_TO_R);

        // R11: later success keeps the code, later fault replaces it
        do_lit(16'h1111);
        do_op(C_DUP);
        do_op(5'b00011);
        do_op(C_DROP);
        do_op(C_DROP);
        do_op(C_DROP);

        // R13: opcode and literal together
        do_op(C_ABORT);
        for (int k = 0; k < 3; k++) begin
            do_lit(16'(16'h0300 + k));
            apply(1'b1, C_DROP, 1'b1, 16'hDEAD);
            do_lit(16'(16'h0310 + k));
            apply(1'b1, C_DUP, 1'b1, 16'hDEAD);
        end

        // R1: reset in mid-run
        do_lit(16'h7777);
        do_op(5'b11111);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_dd = 0; m_rd = 0; m_err = '0;
        compare_all("R1");
        chk("R1", "op_done", 16'(op_done), 16'h0000);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule